// File: doc/BRIEF.md
# Per-Channel Offset and Gain Correction

This block sits behind a multi-channel decimation filter. Up to four channels share one sample stream, and each sample carries a channel index. Each sample is a 24-bit two's-complement word. The block looks up that channel's own trim values and applies them in order. First it removes the channel's offset, clamping the difference to the signed 24-bit range. Then it scales the difference by an unsigned gain in which 0x800000 means 1.0, rounds the product, and clamps it again. Corrected samples leave two clock cycles after they arrive. They keep their channel index and their valid strobe.

A small register port holds one gain word and one offset word per channel, plus a control word. The control word turns offset removal and gain scaling on or off, and it can start a calibration run on one chosen channel. During a run the block adds up 2^CAL_SHIFT raw samples of that channel and takes the floor of their mean. It stores this mean as the channel's offset and then clears the calibration request by itself. Software can therefore null a channel's standing offset from live data, with no computation of its own.

Top module: `chan_trim`

## Requirements
- R1: After reset, out_vld is 0, every gain register reads 0x800000, every offset register reads 0, and the control word reads 0.
- R2: A sample presented with in_vld high at clock edge n appears on out_vld/out_ch/out_data right after edge n+2, with the same channel index; out_vld is low in cycles with no matching input.
- R3: When the offset-enable bit (control bit 0) is set, the offset register of the sample's channel is subtracted from the sample, each channel using only its own offset.
- R4: The offset subtraction saturates: results above 0x7FFFFF give 0x7FFFFF and results below -0x800000 give 0x800000.
- R5: When the gain-enable bit (control bit 1) is set, the value after offset removal is multiplied by the channel's unsigned 24-bit gain, and the result is floor((v*g + 2^22) / 2^23), so 0x800000 is unity gain and halves round upward.
- R6: The gain result saturates to 0x7FFFFF or 0x800000 instead of wrapping.
- R7: With both enable bits clear, out_data equals the input sample unchanged.
- R8: Register map: control word at 0x20 (bit0 offset enable, bit1 gain enable, bit2 calibration run, bits 5:4 calibration channel); gain of channel c at 0x21+c; offset of channel c at 0x25+c. A write takes effect on the clock edge where reg_wr is high. reg_rdata shows the addressed register combinationally. Any other address reads 0 and ignores writes.
- R9: While the calibration bit is set, the block accumulates 2^CAL_SHIFT raw input samples of the calibration channel. It then writes the floor of their mean into that channel's offset register and clears the calibration bit on the same edge. Samples of other channels do not count.
- R10: The sample that completes a calibration run is still corrected with the old offset; the next sample of that channel uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample valid |
| in_ch | input | 2 | Channel index of the input sample |
| in_data | input | 24 | Input sample, two's complement |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for reg_addr |
| out_vld | output | 1 | Corrected sample valid |
| out_ch | output | 2 | Channel index of the corrected sample |
| out_data | output | 24 | Corrected sample, two's complement |

## Verification
The correction path is tried with a single sample per channel under each enable combination. This separates offset removal, gain scaling and plain pass-through. Near-full-scale samples paired with extreme offsets and gains check that each clamp works on its own, and odd products with gains of 1.5 and 0.5 show the rounding direction for positive and negative values. A back-to-back stream across all four channels, each with its own trim values, shows that channels never borrow each other's registers and that the two-cycle alignment holds. The calibration run interleaves a large sample from another channel with every sample of the chosen channel, so a wrong mean shows if foreign samples are counted, and the sample just before and the one after completion show which offset each one used.

// File: rtl/trim_pkg.sv
package trim_pkg;

    localparam int DW  = 24;
    localparam int NCH = 4;
    localparam int CHW = $clog2(NCH);
    localparam int AW  = 8;
    localparam int PW  = 2 * DW + 2;

    localparam logic [AW-1:0] ADDR_CTRL  = 8'h20;
    localparam logic [AW-1:0] ADDR_GAIN0 = 8'h21;
    localparam logic [AW-1:0] ADDR_OFS0  = 8'h25;

    typedef logic [DW-1:0] word_t;

    localparam word_t GAIN_UNITY = {1'b1, {(DW-1){1'b0}}};
    localparam word_t WORD_MAX   = {1'b0, {(DW-1){1'b1}}};
    localparam word_t WORD_MIN   = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [CHW-1:0] cal_ch;
        logic           cal_en;
        logic           gain_en;
        logic           ofs_en;
    } ctrl_t;

    // Clamp a wide signed value into the signed word range.
    function automatic word_t clamp_word(input logic signed [PW-1:0] v);
        logic signed [PW-1:0] hi;
        logic signed [PW-1:0] lo;
        hi = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
        lo = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
        if (v > hi)      return WORD_MAX;
        else if (v < lo) return WORD_MIN;
        else             return v[DW-1:0];
    endfunction

    function automatic logic signed [PW-1:0] sext_word(input word_t w);
        return {{(PW-DW){w[DW-1]}}, w};
    endfunction

endpackage

// File: rtl/trim_regs.sv
module trim_regs
    import trim_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  word_t                   wdata,
    output word_t                   rdata,
    input  logic                    cal_done,
    input  word_t                   cal_mean,
    output ctrl_t                   ctrl,
    output logic [NCH-1:0][DW-1:0]  gains,
    output logic [NCH-1:0][DW-1:0]  offsets
);

    typedef struct packed {
        ctrl_t                   ctrl;
        logic [NCH-1:0][DW-1:0]  gain;
        logic [NCH-1:0][DW-1:0]  ofs;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (addr == ADDR_CTRL) begin
                regs_d.ctrl.ofs_en  = wdata[0];
                regs_d.ctrl.gain_en = wdata[1];
                regs_d.ctrl.cal_en  = wdata[2];
                regs_d.ctrl.cal_ch  = wdata[4 +: CHW];
            end
            for (int c = 0; c < NCH; c++) begin
                if (addr == ADDR_GAIN0 + AW'(c)) regs_d.gain[c] = wdata;
                if (addr == ADDR_OFS0 + AW'(c))  regs_d.ofs[c]  = wdata;
            end
        end
        // Calibration write-back overrides a software write in the same cycle.
        if (cal_done) begin
            regs_d.ofs[regs_q.ctrl.cal_ch] = cal_mean;
            regs_d.ctrl.cal_en             = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl <= '0;
            for (int c = 0; c < NCH; c++) begin
                regs_q.gain[c] <= GAIN_UNITY;
                regs_q.ofs[c]  <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) begin
            rdata[0]          = regs_q.ctrl.ofs_en;
            rdata[1]          = regs_q.ctrl.gain_en;
            rdata[2]          = regs_q.ctrl.cal_en;
            rdata[4 +: CHW]   = regs_q.ctrl.cal_ch;
        end
        for (int c = 0; c < NCH; c++) begin
            if (addr == ADDR_GAIN0 + AW'(c)) rdata = regs_q.gain[c];
            if (addr == ADDR_OFS0 + AW'(c))  rdata = regs_q.ofs[c];
        end
    end

    assign ctrl    = regs_q.ctrl;
    assign gains   = regs_q.gain;
    assign offsets = regs_q.ofs;

endmodule

// File: rtl/trim_cal.sv
module trim_cal
    import trim_pkg::*;
#(
    parameter int K = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            smp_vld,
    input  logic [CHW-1:0]  smp_ch,
    input  word_t           smp_data,
    input  logic            cal_en,
    input  logic [CHW-1:0]  cal_ch,
    output logic            done,
    output word_t           mean
);

    localparam int ACCW = DW + K;

    typedef struct packed {
        logic signed [ACCW-1:0] acc;
        logic [K-1:0]           cnt;
    } cal_t;

    cal_t cal_d, cal_q;
    logic signed [ACCW-1:0] sum;

    always_comb begin
        cal_d = cal_q;
        done  = 1'b0;
        sum   = cal_q.acc + {{K{smp_data[DW-1]}}, smp_data};
        // Low word of sum >>> K is the floor of the mean.
        mean  = sum[K +: DW];
        if (!cal_en) begin
            cal_d = '0;
        end else if (smp_vld && smp_ch == cal_ch) begin
            if (&cal_q.cnt) begin
                done  = 1'b1;
                cal_d = '0;
            end else begin
                cal_d.acc = sum;
                cal_d.cnt = cal_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

endmodule

// File: rtl/trim_dp.sv
module trim_dp
    import trim_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [CHW-1:0]  in_ch,
    input  word_t           in_data,
    input  word_t           ofs_val,
    input  word_t           gain_val,
    input  logic            ofs_en,
    input  logic            gain_en,
    output logic            out_vld,
    output logic [CHW-1:0]  out_ch,
    output word_t           out_data
);

    localparam logic signed [PW-1:0] RND = {{(PW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};

    typedef struct packed {
        logic           s1_vld;
        logic [CHW-1:0] s1_ch;
        word_t          s1_diff;
        word_t          s1_gain;
        logic           s1_gen;
        logic           o_vld;
        logic [CHW-1:0] o_ch;
        word_t          o_data;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [PW-1:0] diff_w;
    logic signed [PW-1:0] mul_a;
    logic signed [PW-1:0] mul_b;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;
    word_t                stage2;

    always_comb begin
        pipe_d = pipe_q;

        // Stage 1: offset removal with clamp.
        diff_w = sext_word(in_data) - (ofs_en ? sext_word(ofs_val) : '0);
        pipe_d.s1_vld  = in_vld;
        pipe_d.s1_ch   = in_ch;
        pipe_d.s1_diff = clamp_word(diff_w);
        pipe_d.s1_gain = gain_val;
        pipe_d.s1_gen  = gain_en;

        // Stage 2: unsigned gain, round half up, clamp.
        mul_a  = sext_word(pipe_q.s1_diff);
        mul_b  = {{(PW-DW){1'b0}}, pipe_q.s1_gain};
        prod   = mul_a * mul_b;
        scaled = (prod + RND) >>> (DW - 1);
        stage2 = pipe_q.s1_gen ? clamp_word(scaled) : pipe_q.s1_diff;

        pipe_d.o_vld  = pipe_q.s1_vld;
        pipe_d.o_ch   = pipe_q.s1_ch;
        pipe_d.o_data = pipe_q.s1_vld ? stage2 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_vld  = pipe_q.o_vld;
    assign out_ch   = pipe_q.o_ch;
    assign out_data = pipe_q.o_data;

endmodule

// File: rtl/chan_trim.sv
module chan_trim
    import trim_pkg::*;
#(
    parameter int CAL_SHIFT = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic [1:0]  in_ch,
    input  logic [23:0] in_data,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [23:0] reg_wdata,
    output logic [23:0] reg_rdata,
    output logic        out_vld,
    output logic [1:0]  out_ch,
    output logic [23:0] out_data
);

    ctrl_t                  ctrl;
    logic [NCH-1:0][DW-1:0] gains;
    logic [NCH-1:0][DW-1:0] offsets;
    logic                   cal_done;
    word_t                  cal_mean;

    trim_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cal_done (cal_done),
        .cal_mean (cal_mean),
        .ctrl     (ctrl),
        .gains    (gains),
        .offsets  (offsets)
    );

    trim_cal #(.K(CAL_SHIFT)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (in_vld),
        .smp_ch   (in_ch),
        .smp_data (in_data),
        .cal_en   (ctrl.cal_en),
        .cal_ch   (ctrl.cal_ch),
        .done     (cal_done),
        .mean     (cal_mean)
    );

    trim_dp u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (in_vld),
        .in_ch    (in_ch),
        .in_data  (in_data),
        .ofs_val  (offsets[in_ch]),
        .gain_val (gains[in_ch]),
        .ofs_en   (ctrl.ofs_en),
        .gain_en  (ctrl.gain_en),
        .out_vld  (out_vld),
        .out_ch   (out_ch),
        .out_data (out_data)
    );

endmodule

// File: rtl/trim_chk.sv
module trim_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic [1:0]  in_ch,
    input logic [23:0] in_data,
    input logic        out_vld,
    input logic [1:0]  out_ch,
    input logic [23:0] out_data,
    input logic        ofs_en,
    input logic        gain_en,
    input logic        cal_en,
    input logic        cal_done
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_vld == $past(in_vld, 2))); // R2

    AST_CHANNEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_vld) |-> (out_ch == $past(in_ch, 2))); // R2

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_vld && $past(!ofs_en && !gain_en, 2))
            |-> (out_data == $past(in_data, 2))); // R7

    AST_CAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_en); // R9

    AST_CAL_ONLY_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> cal_en); // R9

endmodule

bind chan_trim trim_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_ch    (in_ch),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_ch   (out_ch),
    .out_data (out_data),
    .ofs_en   (ctrl.ofs_en),
    .gain_en  (ctrl.gain_en),
    .cal_en   (ctrl.cal_en),
    .cal_done (cal_done)
);

// File: tb/sim_chan_trim.sv
module sim_chan_trim;

    localparam int CLK_PERIOD = 10;
    localparam int K = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [1:0]  in_ch = '0;
    logic [23:0] in_data = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic        out_vld;
    logic [1:0]  out_ch;
    logic [23:0] out_data;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    logic [23:0] g_sh [4];
    logic [23:0] o_sh [4];
    bit oe_sh = 1'b0;
    bit ge_sh = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_trim #(.CAL_SHIFT(K)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch), .in_data(in_data),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_vld(out_vld), .out_ch(out_ch), .out_data(out_data)
    );

    function automatic longint clampv(longint v);
        if (v > 64'sd8388607)  return 64'sd8388607;
        if (v < -64'sd8388608) return -64'sd8388608;
        return v;
    endfunction

    function automatic logic [23:0] model(logic [23:0] d, logic [23:0] o, logic [23:0] g,
                                          bit oe, bit ge);
        longint v;
        v = longint'(signed'(d));
        if (oe) v = clampv(v - longint'(signed'(o)));
        if (ge) v = clampv((v * longint'(g) + (64'sd1 <<< 22)) >>> 23);
        return v[23:0];
    endfunction

    task automatic check(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [23:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 8'h20) begin oe_sh = d[0]; ge_sh = d[1]; end
        if (a >= 8'h21 && a <= 8'h24) g_sh[a - 8'h21] = d;
        if (a >= 8'h25 && a <= 8'h28) o_sh[a - 8'h25] = d;
    endtask

    task automatic rd_check(logic [7:0] a, logic [23:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic send_one(logic [1:0] ch, logic [23:0] d, logic [23:0] exp, string tag);
        @(negedge clk);
        in_vld = 1'b1; in_ch = ch; in_data = d;
        @(negedge clk);
        in_vld = 1'b0;
        @(negedge clk);
        check(out_vld === 1'b1 && out_ch === ch && out_data === exp, tag, out_data, exp);
    endtask

    task automatic send_model(logic [1:0] ch, logic [23:0] d, string tag);
        send_one(ch, d, model(d, o_sh[ch], g_sh[ch], oe_sh, ge_sh), tag);
    endtask

    task automatic t_reset;
        #1;
        check(out_vld === 1'b0, "R1 out_vld after reset", {23'd0, out_vld}, 24'd0);
        rd_check(8'h20, 24'h0, "R1 ctrl reset");
        for (int c = 0; c < 4; c++) begin
            rd_check(8'h21 + 8'(c), 24'h800000, "R1 gain reset");
            rd_check(8'h25 + 8'(c), 24'h000000, "R1 offset reset");
        end
    endtask

    task automatic t_passthru;
        wr(8'h25, 24'h001234);
        wr(8'h21, 24'h300000);
        send_one(2'd0, 24'h0ABCDE, 24'h0ABCDE, "R7 pass positive");
        send_one(2'd3, 24'hF00001, 24'hF00001, "R7 pass negative");
    endtask

    task automatic t_offset;
        wr(8'h20, 24'h000001);
        wr(8'h25, 24'h000010);
        wr(8'h26, 24'hFFFFF0);
        send_model(2'd0, 24'h000100, "R3 offset ch0");
        send_one(2'd1, 24'h000100, 24'h000110, "R3 offset ch1 negative offset");
        wr(8'h26, 24'h7FFFFF);
        wr(8'h28, 24'h800000);
        send_one(2'd1, 24'h800000, 24'h800000, "R4 low clamp");
        send_one(2'd3, 24'h7FFFFF, 24'h7FFFFF, "R4 high clamp");
    endtask

    task automatic t_gain;
        wr(8'h20, 24'h000002);
        wr(8'h21, 24'hC00000);
        send_one(2'd0, 24'h000003, 24'h000005, "R5 gain 1.5 positive round");
        send_one(2'd0, 24'hFFFFFD, 24'hFFFFFC, "R5 gain 1.5 negative round");
        wr(8'h22, 24'h400000);
        send_one(2'd1, 24'h000101, 24'h000081, "R5 gain 0.5 round half up");
        wr(8'h23, 24'hFFFFFF);
        send_one(2'd2, 24'h7FFFFF, 24'h7FFFFF, "R6 gain high clamp");
        send_one(2'd2, 24'h800000, 24'h800000, "R6 gain low clamp");
    endtask

    task automatic t_stream;
        logic [23:0] d   [4];
        logic [23:0] exp [4];
        wr(8'h20, 24'h000003);
        wr(8'h21, 24'h900000); wr(8'h22, 24'h700000);
        wr(8'h23, 24'h800000); wr(8'h24, 24'hA00000);
        wr(8'h25, 24'h000100); wr(8'h26, 24'hFFFF00);
        wr(8'h27, 24'h123456); wr(8'h28, 24'h000000);
        d[0] = 24'h012345; d[1] = 24'hFEDCBA; d[2] = 24'h400000; d[3] = 24'hC00001;
        for (int i = 0; i < 4; i++) exp[i] = model(d[i], o_sh[i], g_sh[i], 1'b1, 1'b1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2)
                check(out_vld === 1'b1 && out_ch === 2'(i-2) && out_data === exp[i-2],
                      "R2 R3 R5 stream", out_data, exp[i-2]);
            if (i < 4) begin
                in_vld = 1'b1; in_ch = 2'(i); in_data = d[i];
            end else begin
                in_vld = 1'b0;
            end
        end
        @(negedge clk);
        check(out_vld === 1'b0, "R2 valid drops after stream", {23'd0, out_vld}, 24'd0);
    endtask

    task automatic t_regmap;
        wr(8'h29, 24'hABCDEF);
        rd_check(8'h29, 24'h000000, "R8 unmapped reads zero");
        rd_check(8'h1F, 24'h000000, "R8 unmapped below map");
        rd_check(8'h27, 24'h123456, "R8 offset readback");
        rd_check(8'h24, 24'hA00000, "R8 gain readback");
        rd_check(8'h20, 24'h000003, "R8 ctrl readback");
    endtask

    task automatic t_cal;
        longint sum = 0;
        logic [23:0] v;
        logic [23:0] mean;
        wr(8'h27, 24'h000100);
        wr(8'h20, 24'h000025);
        for (int i = 0; i < 16; i++) begin
            send_model(2'd1, 24'h700000, "R9 foreign channel during cal");
            v = 24'(-1000 + 37 * i);
            sum += longint'(signed'(v));
            if (i == 15) send_one(2'd2, v, model(v, 24'h000100, 24'h800000, 1'b1, 1'b0),
                                  "R10 last cal sample uses old offset");
            else         send_model(2'd2, v, "R9 cal sample corrected");
            if (i == 7) rd_check(8'h20, 24'h000025, "R9 cal still running");
        end
        mean = 24'(sum >>> K);
        rd_check(8'h20, 24'h000021, "R9 cal bit cleared");
        rd_check(8'h27, mean, "R9 offset holds mean");
        o_sh[2] = mean;
        send_one(2'd2, 24'h000000, model(24'h0, mean, 24'h800000, 1'b1, 1'b0),
                 "R10 next sample uses new offset");
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin g_sh[c] = 24'h800000; o_sh[c] = 24'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_offset();
        t_gain();
        t_stream();
        t_regmap();
        t_cal();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog act=%h exp=%h", 24'd1, 24'd0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule